// File: doc/BRIEF.md
# Hinted Fetch Redirect Table

This block is a small, software-loaded redirect table that sits beside the instruction fetch address generator. Each entry holds a pair: the address of a bundle that contains a branch, and the target address of that branch. Compiler-placed hint operations install these pairs through a write port. Each cycle the current fetch address is compared against every valid entry. On a match, the next fetch address becomes the stored target. On a miss, fetch advances to the next sequential two-bundle block.

The redirect is combinational from the fetch address and the registered table contents. A hit therefore steers the very next fetch with no extra bubble. It is the first and fastest level of a larger prediction hierarchy.

A later address-calculation stage can suppress a single entry, for example when a loop has finished. A pipeline flush clears the whole table. Bundles are 16 bytes, and each fetch covers two bundles (32 bytes).

Top module: `fetch_hint_redirect`

## Requirements
- R1: After reset every entry is invalid, so `hit_o` is 0 for any `pc_i`.
- R2: When no valid entry matches, `hit_o` is 0 and `next_pc_o` equals `pc_i + 32`, wrapping modulo 2^ADDR_W.
- R3: When a valid entry's stored branch address matches `pc_i`, `hit_o` is 1 in the same cycle. `next_pc_o` is then that entry's target with bits [3:0] forced to zero.
- R4: The match uses only address bits [ADDR_W-1:4]. Bits [3:0] of `pc_i` and of the installed branch address play no part in it.
- R5: When several valid entries match, the entry with the lowest index supplies the target.
- R6: A write with `wr_en_i` high installs the pair at `wr_idx_i` and marks it valid. The new entry takes part in matching from the cycle after the write, and not in the cycle of the write itself.
- R7: A suppress with `sup_en_i` high makes entry `sup_idx_i` invalid from the next cycle. When a write targets the same index in the same cycle, the suppress wins.
- R8: `flush_i` makes all entries invalid from the next cycle. It overrides a write or a suppress in the same cycle.
- R9: Writing an index that already holds an entry replaces its pair, so the old branch address no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | ADDR_W | Current fetch address |
| wr_en_i | input | 1 | Install a hint pair |
| wr_idx_i | input | IDX_W | Entry index for the install |
| wr_br_addr_i | input | ADDR_W | Address of the bundle that holds the branch |
| wr_tgt_i | input | ADDR_W | Branch target address |
| sup_en_i | input | 1 | Suppress one entry |
| sup_idx_i | input | IDX_W | Entry index to suppress |
| flush_i | input | 1 | Invalidate all entries |
| next_pc_o | output | ADDR_W | Next fetch address |
| hit_o | output | 1 | A valid entry matched `pc_i` |

## Verification
`hit_o` and `next_pc_o` follow `pc_i` within the same cycle. A write, a suppress or a flush changes them only after the next rising edge.

The bench drives every input just after a falling edge and samples the outputs one nanosecond later, still in the low phase. Each lookup is therefore checked against the table state left by the previous rising edge. In the cycle of a table update, the bench checks before the edge that the pending change is not yet visible. It then updates its own model one nanosecond after the edge and checks the new state at the next falling edge.

// File: rtl/fhr_pkg.sv
package fhr_pkg;
  localparam int unsigned BUNDLE_BYTES  = 16;
  localparam int unsigned FETCH_BUNDLES = 2;
  localparam int unsigned FETCH_BYTES   = BUNDLE_BYTES * FETCH_BUNDLES;
  localparam int unsigned BUNDLE_LSB    = $clog2(BUNDLE_BYTES);
endpackage

// File: rtl/fhr_entry.sv
module fhr_entry #(
  parameter int unsigned TAG_W = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] br_tag_i,
  input  logic [TAG_W-1:0] tgt_tag_i,
  input  logic [TAG_W-1:0] pc_tag_i,
  output logic             valid_o,
  output logic             match_o,
  output logic [TAG_W-1:0] tgt_tag_o
);
  logic             valid_q;
  logic [TAG_W-1:0] br_q, tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      br_q  <= '0;
      tgt_q <= '0;
    end else if (set_i) begin
      br_q  <= br_tag_i;
      tgt_q <= tgt_tag_i;
    end
  end

  assign valid_o   = valid_q;
  assign match_o   = valid_q && (pc_tag_i == br_q);
  assign tgt_tag_o = tgt_q;
endmodule

// File: rtl/fhr_prio_sel.sv
module fhr_prio_sel #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 44
) (
  input  logic [N-1:0]        match_i,
  input  logic [N-1:0][W-1:0] data_i,
  output logic                any_o,
  output logic [W-1:0]        data_o
);
  // scan downward so the lowest matching index is the last assignment
  always_comb begin
    data_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) data_o = data_i[i];
    end
  end

  assign any_o = |match_i;
endmodule

// File: rtl/fetch_hint_redirect.sv
module fetch_hint_redirect #(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_br_addr_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  logic              sup_en_i,
  input  logic [IDX_W-1:0]  sup_idx_i,
  input  logic              flush_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              hit_o
);
  import fhr_pkg::*;

  localparam int unsigned LSB   = BUNDLE_LSB;
  localparam int unsigned TAG_W = ADDR_W - LSB;

  logic [NUM_ENT-1:0]            valid_q;
  logic [NUM_ENT-1:0]            match;
  logic [NUM_ENT-1:0][TAG_W-1:0] tgt_tags;
  logic [TAG_W-1:0]              sel_tag;
  logic [TAG_W-1:0]              pc_tag;
  logic                          unused_low;

  assign pc_tag     = pc_i[ADDR_W-1:LSB];
  assign unused_low = ^{wr_br_addr_i[LSB-1:0], wr_tgt_i[LSB-1:0]};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic set, clr;
    assign set = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign clr = flush_i || (sup_en_i && (sup_idx_i == IDX_W'(g)));

    fhr_entry #(.TAG_W(TAG_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set),
      .clr_i     (clr),
      .br_tag_i  (wr_br_addr_i[ADDR_W-1:LSB]),
      .tgt_tag_i (wr_tgt_i[ADDR_W-1:LSB]),
      .pc_tag_i  (pc_tag),
      .valid_o   (valid_q[g]),
      .match_o   (match[g]),
      .tgt_tag_o (tgt_tags[g])
    );
  end

  fhr_prio_sel #(.N(NUM_ENT), .W(TAG_W)) i_sel (
    .match_i (match),
    .data_i  (tgt_tags),
    .any_o   (hit_o),
    .data_o  (sel_tag)
  );

  assign next_pc_o = hit_o ? {sel_tag, {LSB{1'b0}}}
                           : pc_i + ADDR_W'(FETCH_BYTES);
endmodule

// File: rtl/fhr_chk.sv
module fhr_chk #(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned IDX_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_i,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic              sup_en_i,
  input logic [IDX_W-1:0]  sup_idx_i,
  input logic              flush_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              hit_o,
  input logic [NUM_ENT-1:0] valid_q
);
  import fhr_pkg::*;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> valid_q == '0);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == pc_i + ADDR_W'(FETCH_BYTES));

  // R3
  hit_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (next_pc_o[BUNDLE_LSB-1:0] == '0) && (valid_q != '0));

  // R6
  install_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !flush_i && !(sup_en_i && sup_idx_i == wr_idx_i)
      |=> valid_q[$past(wr_idx_i)]);

  // R7
  suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_en_i |=> !valid_q[$past(sup_idx_i)]);

  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0) && !hit_o);
endmodule

bind fetch_hint_redirect fhr_chk #(
  .ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .IDX_W(IDX_W)
) i_fhr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .wr_en_i(wr_en_i),
  .wr_idx_i(wr_idx_i), .sup_en_i(sup_en_i), .sup_idx_i(sup_idx_i),
  .flush_i(flush_i), .next_pc_o(next_pc_o), .hit_o(hit_o), .valid_q(valid_q)
);

// File: tb/test_fetch_hint_redirect.sv
module test_fetch_hint_redirect;
  localparam int unsigned AW = 16;
  localparam int unsigned NE = 4;
  localparam int unsigned IW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [AW-1:0] wr_br_addr_i = '0;
  logic [AW-1:0] wr_tgt_i = '0;
  logic          sup_en_i = 1'b0;
  logic [IW-1:0] sup_idx_i = '0;
  logic          flush_i = 1'b0;
  logic [AW-1:0] next_pc_o;
  logic          hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          m_v  [NE];
  logic [AW-1:0] m_br [NE];
  logic [AW-1:0] m_tg [NE];

  always #5 clk_i = ~clk_i;

  fetch_hint_redirect #(.ADDR_W(AW), .NUM_ENT(NE)) i_fetch_hint_redirect (
    .clk_i, .rst_ni, .pc_i, .wr_en_i, .wr_idx_i, .wr_br_addr_i, .wr_tgt_i,
    .sup_en_i, .sup_idx_i, .flush_i, .next_pc_o, .hit_o
  );

  task automatic look(input string req, input logic [AW-1:0] pc);
    logic          e_hit = 1'b0;
    logic [AW-1:0] e_nx  = pc + AW'(32);
    pc_i = pc;
    #1;
    for (int i = 0; i < NE; i++) begin
      if (!e_hit && m_v[i] && (m_br[i][AW-1:4] == pc[AW-1:4])) begin
        e_hit = 1'b1;
        e_nx  = {m_tg[i][AW-1:4], 4'h0};
      end
    end
    checks++;
    if (hit_o !== e_hit || next_pc_o !== e_nx) begin
      errors++;
      $display("FAIL %s pc=%h hit=%b next=%h expected hit=%b next=%h",
               req, pc, hit_o, next_pc_o, e_hit, e_nx);
    end
  endtask

  // one cycle of table traffic; lookup at pc is checked before the edge (R6)
  task automatic cyc(input logic we, input int wi, input logic [AW-1:0] br,
                     input logic [AW-1:0] tg, input logic se, input int si,
                     input logic fl, input logic [AW-1:0] pc);
    @(negedge clk_i);
    wr_en_i = we; wr_idx_i = IW'(wi); wr_br_addr_i = br; wr_tgt_i = tg;
    sup_en_i = se; sup_idx_i = IW'(si); flush_i = fl;
    look("R6 pre-edge", pc);
    @(posedge clk_i);
    #1;
    if (fl) begin
      for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
    end else begin
      if (we) begin m_v[wi] = 1'b1; m_br[wi] = br; m_tg[wi] = tg; end
      if (se) m_v[si] = 1'b0;
    end
    wr_en_i = 1'b0; sup_en_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic sweep(input string req, input logic [AW-1:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      look(req, base + AW'(k * 16) + AW'((k * 5) % 16));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_br[i] = '0; m_tg[i] = '0; end
    repeat (3) @(negedge clk_i);
    look("R1 in reset", 16'h0100);
    rst_ni = 1'b1;
    sweep("R1 R2 empty table", 16'h0000, 32);
    @(negedge clk_i); look("R2 wrap", 16'hFFF0);
    @(negedge clk_i); look("R2 wrap low bits", 16'hFFE9);

    // R6: not visible in the write cycle, visible afterwards
    cyc(1, 0, 16'h0100, 16'h0A37, 0, 0, 0, 16'h0100);
    sweep("R3 R4 single entry", 16'h00C0, 16);
    cyc(1, 2, 16'h020C, 16'h1234, 0, 0, 0, 16'h0200);
    @(negedge clk_i); look("R4 stored low bits", 16'h0201);

    // R5: entries 1 and 3 share a branch address, 3 written first
    cyc(1, 3, 16'h0300, 16'h3330, 0, 0, 0, 16'h0300);
    cyc(1, 1, 16'h0305, 16'h1110, 0, 0, 0, 16'h0300);
    @(negedge clk_i); look("R5 lowest index", 16'h030F);
    sweep("R3 R5 full table", 16'h0000, 64);

    // R9: overwrite entry 1
    cyc(1, 1, 16'h0500, 16'h5550, 0, 0, 0, 16'h0500);
    @(negedge clk_i); look("R9 old pair gone", 16'h0300);
    @(negedge clk_i); look("R9 new pair", 16'h0508);

    // R7: suppress, and suppress beating a write to the same index
    cyc(0, 0, '0, '0, 1, 0, 0, 16'h0100);
    @(negedge clk_i); look("R7 suppressed", 16'h0100);
    cyc(1, 2, 16'h0700, 16'h7770, 1, 2, 0, 16'h0700);
    @(negedge clk_i); look("R7 suppress wins", 16'h0700);
    @(negedge clk_i); look("R7 other entry kept", 16'h0504);

    // R8: flush over a write
    cyc(1, 0, 16'h0900, 16'h9990, 0, 0, 1, 16'h0500);
    sweep("R8 flushed", 16'h0000, 160);
    cyc(1, 0, 16'hFFF0, 16'h0040, 0, 0, 0, 16'hFFF0);
    @(negedge clk_i); look("R3 top address", 16'hFFFC);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule